// File: doc/BRIEF.md
# Self-Test and Soft-Reset Sequencer

This block sequences two host-initiated actions for a serial command/response bus terminal. The first is a soft reset. A host write to one decoded address pulses a reset line into the encoder, decoder and protocol logic for a fixed, short number of clocks. The block's own flags are not cleared beyond what is listed below. Command intake stays halted after the reset until the host writes a resume address.

The second action is a timed built-in self-test. A write to the test address starts it, but only after a soft reset has armed it. While the test runs, the block asks the encoder to loop its output back into both channel decoders. A stand-in compare stage reports per-channel mismatches to the block. A mismatch on channel A or on channel B latches a failure flag for that channel. The two flags appear at fixed positions in a 16-bit result word and are ORed onto a failure pin.

In remote-terminal mode, incoming bus commands are gated off for the whole test window. Writes carry no data that matters, so the block sees only a write strobe and an address.

Top module: `selftest_reset_ctrl`

## Requirements
- R1: After the asynchronous active-low reset `rstN`, the outputs `codecReset`, `testBusy`, `loopEnable`, `failPin` and all of `bitWord` are 0, and `cmdEnable` is 1.
- R2: A write (`wrValid`=1) to `wrAddr`=RESET_ADDR (default 4'h8) drives `codecReset` high from the cycle after the write for exactly RST_CYCLES cycles. The default of 40 cycles at 50 MHz is below 1 µs. A further reset write restarts the pulse.
- R3: From the cycle after a reset write, `cmdEnable` is 0 and stays 0 until a write to RESUME_ADDR (default 4'hA).
- R4: A write to TEST_ADDR (default 4'h9) starts the test only when the block is idle and armed. A reset write arms the block and starting a test disarms it. A test write made before any reset write, during the reset pulse, or after a finished test with no reset in between has no effect.
- R5: Once the test starts, `testBusy` and `loopEnable` are high from the cycle after the write for exactly TEST_CYCLES cycles. The default of 5000 cycles at 50 MHz is 100 µs.
- R6: A cycle with `lbValid`=1 and `lbMissA`=1 (or `lbMissB`=1) while `testBusy` is high sets the channel A (or channel B) failure flag. Mismatches while idle, and mismatch inputs with `lbValid`=0, set nothing.
- R7: `bitWord[14]` is the channel A failure flag and `bitWord[15]` is the channel B flag. All other bits of `bitWord` are 0. `failPin` is the OR of the two flags.
- R8: Failure flags stay set after the test ends and clear only on the next reset write, in the cycle after it.
- R9: While `testBusy` is high with `rtMode`=1, `cmdEnable` is 0. With `rtMode`=0 and no halt pending, `cmdEnable` stays 1 during the test.
- R10: A reset write during the test ends the test in the next cycle (`testBusy` 0, `codecReset` 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrValid | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W (4) | Host write address |
| rtMode | input | 1 | 1 = remote-terminal mode, 0 = controller mode |
| lbValid | input | 1 | Loopback compare result valid |
| lbMissA | input | 1 | Loopback mismatch on channel A |
| lbMissB | input | 1 | Loopback mismatch on channel B |
| codecReset | output | 1 | Reset pulse to encoder, decoders and protocol logic |
| loopEnable | output | 1 | Requests encoder-to-decoder wrap-around |
| testBusy | output | 1 | Self-test in progress |
| cmdEnable | output | 1 | Bus command intake permitted |
| bitWord | output | 16 | Self-test result word |
| failPin | output | 1 | Any channel failed |

## Verification
Most control faults show up within one clock at `codecReset`, `testBusy` or `cmdEnable`. A wrong sequencer state or a wrongly kept arming flag is seen as a test that starts or fails to start on the cycle after the write. A counter off by one is caught only when the pulse or window ends, up to 5000 cycles later. For that reason every window is counted in full. Failure flags are read both at the end of each test and after the next reset, so that a flag stuck high, a flag that never latches, or two swapped channel positions are all exposed at `bitWord`.

// File: rtl/strs_pkg.sv
package strs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_TEST
  } seqState_e;

  typedef struct packed {
    logic loadRst;
    logic loadTest;
    logic clrFail;
    logic sampleEn;
  } seqStrobe_t;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/strs_datapath.sv
module strs_datapath
  import strs_pkg::*;
#(
  parameter int RST_CYCLES  = 40,
  parameter int TEST_CYCLES = 5000,
  parameter int CNT_W       = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              lbValid,
  input  logic [NUM_CH-1:0] lbMiss,
  output logic              cntDone,
  output logic [NUM_CH-1:0] failFlag
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadRst) begin
      cnt <= CNT_W'(RST_CYCLES - 1);
    end else if (strobe.loadTest) begin
      cnt <= CNT_W'(TEST_CYCLES - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        failFlag[ch] <= 1'b0;
      end else if (strobe.clrFail) begin
        failFlag[ch] <= 1'b0;
      end else if (strobe.sampleEn && lbValid && lbMiss[ch]) begin
        failFlag[ch] <= 1'b1;
      end
    end

    // R8: a set flag survives until a programmed reset clears it
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (failFlag[ch] && !strobe.clrFail) |=> failFlag[ch]);

    // R6: a flag can only rise from a sample taken inside the test window
    a_r6_fail_in_window: assert property (@(posedge clk) disable iff (!rstN)
      $rose(failFlag[ch]) |-> $past(strobe.sampleEn && lbValid && lbMiss[ch]));
  end

endmodule

// File: rtl/strs_ctrl.sv
module strs_ctrl
  import strs_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR  = 4'h8,
  parameter logic [ADDR_W-1:0] TEST_ADDR   = 4'h9,
  parameter logic [ADDR_W-1:0] RESUME_ADDR = 4'hA,
  parameter int              RST_CYCLES  = 40,
  parameter int              TEST_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rtMode,
  input  logic              cntDone,
  output seqStrobe_t        strobe,
  output logic              codecReset,
  output logic              testBusy,
  output logic              cmdEnable
);

  seqState_e state;
  logic      armed;
  logic      halted;
  logic      rstWr, testWr, resumeWr, startOk;

  assign rstWr    = wrValid && (wrAddr == RESET_ADDR);
  assign testWr   = wrValid && (wrAddr == TEST_ADDR);
  assign resumeWr = wrValid && (wrAddr == RESUME_ADDR);
  assign startOk  = testWr && armed && (state == ST_IDLE) && !rstWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      armed  <= 1'b0;
      halted <= 1'b0;
    end else begin
      if (rstWr) begin
        state  <= ST_PULSE;
        armed  <= 1'b1;
        halted <= 1'b1;
      end else begin
        if (resumeWr) halted <= 1'b0;
        unique case (state)
          ST_IDLE: begin
            if (startOk) begin
              state <= ST_TEST;
              armed <= 1'b0;
            end
          end
          ST_PULSE: if (cntDone) state <= ST_IDLE;
          ST_TEST:  if (cntDone) state <= ST_IDLE;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadRst  = rstWr;
    strobe.clrFail  = rstWr;
    strobe.loadTest = startOk;
    strobe.sampleEn = (state == ST_TEST);
  end

  assign codecReset = (state == ST_PULSE);
  assign testBusy   = (state == ST_TEST);
  assign cmdEnable  = !halted && !codecReset && !(testBusy && rtMode);

  // ---------------- checks ----------------
  logic [31:0] pulseLen, testLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseLen <= '0;
      testLen  <= '0;
    end else begin
      if (rstWr)               pulseLen <= '0;
      else if (codecReset)     pulseLen <= pulseLen + 1'b1;
      if (startOk)             testLen  <= '0;
      else if (testBusy)       testLen  <= testLen + 1'b1;
    end
  end

  // R2: pulse length is exactly RST_CYCLES
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(codecReset) |-> (pulseLen == 32'(RST_CYCLES)));

  // R5: an unaborted test window is exactly TEST_CYCLES long
  a_r5_window_len: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(testBusy) && !codecReset) |-> (testLen == 32'(TEST_CYCLES)));

  // R4: a test only begins from an armed idle state
  a_r4_armed_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testBusy) |-> ($past(armed) && $past(state == ST_IDLE)));

  // R3: commands stay halted the cycle after a reset write
  a_r3_halt_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> !cmdEnable);

  // R10: a reset write during the test ends it at once
  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    (testBusy && rstWr) |=> (!testBusy && codecReset));

  a_r4_onehot_state: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({codecReset, testBusy}));

endmodule

// File: rtl/selftest_reset_ctrl.sv
module selftest_reset_ctrl
  import strs_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR  = 4'h8,
  parameter logic [ADDR_W-1:0] TEST_ADDR   = 4'h9,
  parameter logic [ADDR_W-1:0] RESUME_ADDR = 4'hA,
  parameter int              RST_CYCLES  = 40,
  parameter int              TEST_CYCLES = 5000,
  parameter int              FAIL_A_BIT  = 14,
  parameter int              FAIL_B_BIT  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rtMode,
  input  logic              lbValid,
  input  logic              lbMissA,
  input  logic              lbMissB,
  output logic              codecReset,
  output logic              loopEnable,
  output logic              testBusy,
  output logic              cmdEnable,
  output logic [15:0]       bitWord,
  output logic              failPin
);

  localparam int MAX_CYC = (TEST_CYCLES > RST_CYCLES) ? TEST_CYCLES : RST_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  seqStrobe_t        strobe;
  logic              cntDone;
  logic [NUM_CH-1:0] failFlag;

  strs_ctrl #(
    .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .TEST_ADDR(TEST_ADDR),
    .RESUME_ADDR(RESUME_ADDR), .RST_CYCLES(RST_CYCLES), .TEST_CYCLES(TEST_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .rtMode(rtMode), .cntDone(cntDone), .strobe(strobe),
    .codecReset(codecReset), .testBusy(testBusy), .cmdEnable(cmdEnable)
  );

  strs_datapath #(
    .RST_CYCLES(RST_CYCLES), .TEST_CYCLES(TEST_CYCLES), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lbValid(lbValid),
    .lbMiss({lbMissB, lbMissA}), .cntDone(cntDone), .failFlag(failFlag)
  );

  always_comb begin
    bitWord             = '0;
    bitWord[FAIL_A_BIT] = failFlag[0];
    bitWord[FAIL_B_BIT] = failFlag[1];
  end

  assign failPin    = |failFlag;
  assign loopEnable = testBusy;

  // R9: remote-terminal mode blocks commands for the whole test
  a_r9_rt_block: assert property (@(posedge clk) disable iff (!rstN)
    (testBusy && rtMode) |-> !cmdEnable);

  // R7: pin agrees with the result word
  a_r7_pin_word: assert property (@(posedge clk) disable iff (!rstN)
    failPin == (bitWord[FAIL_A_BIT] || bitWord[FAIL_B_BIT]));

endmodule

// File: tb/selftest_reset_ctrl_tb_top.sv
module selftest_reset_ctrl_tb_top;

  localparam int RSTC = 40;
  localparam int TSTC = 5000;
  localparam logic [3:0] A_RST = 4'h8;
  localparam logic [3:0] A_TST = 4'h9;
  localparam logic [3:0] A_RES = 4'hA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [3:0] wrAddr = '0;
  logic rtMode = 1'b0;
  logic lbValid = 1'b0;
  logic lbMissA = 1'b0;
  logic lbMissB = 1'b0;
  logic codecReset, loopEnable, testBusy, cmdEnable, failPin;
  logic [15:0] bitWord;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  selftest_reset_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .rtMode(rtMode), .lbValid(lbValid), .lbMissA(lbMissA), .lbMissB(lbMissB),
    .codecReset(codecReset), .loopEnable(loopEnable), .testBusy(testBusy),
    .cmdEnable(cmdEnable), .bitWord(bitWord), .failPin(failPin)
  );

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] a);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // measures the reset pulse; called right after hostWrite(A_RST)
  task automatic waitPulse();
    int n = 0;
    while (codecReset && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R2 pulse length", n, RSTC);
  endtask

  // full test window with a mismatch pattern; pattern bit0 = A, bit1 = B
  task automatic runTest(input int pat);
    int n = 0;
    hostWrite(A_TST);
    check("R5 busy after start", testBusy, 1);
    check("R5 loopEnable", loopEnable, 1);
    while (testBusy && n < 20000) begin
      lbValid = 1'b0; lbMissA = 1'b0; lbMissB = 1'b0;
      if (n == 50) begin           // R6: mismatch without valid is ignored
        lbMissA = 1'b1; lbMissB = 1'b1;
      end
      if (n == 300) begin
        lbValid = 1'b1;
        lbMissA = pat[0]; lbMissB = pat[1];
      end
      if (n == 60) check("R6 no flag from invalid", failPin, 0);
      n++;
      @(negedge clk);
    end
    lbValid = 1'b0; lbMissA = 1'b0; lbMissB = 1'b0;
    check("R5 window length", n, TSTC);
    check("R7 bit14 chan A", bitWord[14], pat[0]);
    check("R7 bit15 chan B", bitWord[15], pat[1]);
    check("R7 other bits zero", int'(bitWord & 16'h3FFF), 0);
    check("R7 failPin", failPin, (pat != 0) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 codecReset", codecReset, 0);
    check("R1 testBusy", testBusy, 0);
    check("R1 loopEnable", loopEnable, 0);
    check("R1 failPin", failPin, 0);
    check("R1 bitWord", bitWord, 0);
    check("R1 cmdEnable", cmdEnable, 1);

    // R4: test write before any reset write
    hostWrite(A_TST);
    check("R4 unarmed start ignored", testBusy, 0);
    repeat (3) @(negedge clk);
    check("R4 unarmed still idle", testBusy, 0);

    // R2/R3 reset pulse and halt
    hostWrite(A_RST);
    check("R3 halted during pulse", cmdEnable, 0);
    // R4: test write during the pulse is ignored; R2 re-write restarts pulse
    hostWrite(A_TST);
    check("R4 start in pulse ignored", testBusy, 0);
    check("R2 pulse still high", codecReset, 1);
    hostWrite(A_RST);
    waitPulse();
    check("R3 halted after pulse", cmdEnable, 0);
    check("R4 idle after pulse", testBusy, 0);
    hostWrite(A_RES);
    check("R3 resume", cmdEnable, 1);

    // R6: mismatch while idle ignored
    @(negedge clk);
    lbValid = 1'b1; lbMissA = 1'b1; lbMissB = 1'b1;
    @(negedge clk);
    lbValid = 1'b0; lbMissA = 1'b0; lbMissB = 1'b0;
    check("R6 idle mismatch ignored", failPin, 0);

    // R9: armed from the earlier reset; RT mode blocks commands
    rtMode = 1'b1;
    hostWrite(A_TST);
    check("R9 rt blocked", cmdEnable, 0);
    rtMode = 1'b0;
    #1 check("R9 bc not blocked", cmdEnable, 1);
    // R10 abort
    hostWrite(A_RST);
    check("R10 busy dropped", testBusy, 0);
    check("R10 pulse started", codecReset, 1);
    waitPulse();

    // sweep of channel patterns
    for (int p = 0; p < 4; p++) begin
      hostWrite(A_RST);
      waitPulse();
      check("R8 cleared by reset", bitWord, 0);
      runTest(p);
      repeat (5) @(negedge clk);
      check("R8 A sticky", bitWord[14], p & 1);
      check("R8 B sticky", bitWord[15], (p >> 1) & 1);
      // R4: second start without reset ignored
      hostWrite(A_TST);
      check("R4 rerun needs reset", testBusy, 0);
    end
    hostWrite(A_RST);
    check("R8 clear next cycle", bitWord, 0);
    waitPulse();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule